// File: doc/BRIEF.md
# Power-Down and Wakeup Controller

This block manages power-down for a small microcontroller core. Software writes a power-control register to freeze the processor. While frozen, the block withdraws the clock enable of the processor clock and tells the pad ring to release the external memory bus so the pads float to their pull-ups. The block keeps running on the always-on slow clock and watches three wake sources: a match on enabled I/O pins, a new timer-2 overflow request and a pulse from the audio detector.

When a permitted source fires, the block clears the power-down bit and re-enables the processor clock. No reset occurs, so every bit of processor state is kept. The processor clock used after wakeup comes from a select bit chosen before entry, and it does not depend on the clock that was running earlier. The power-control register also chooses between two modes. In Sleep mode only pin matches can wake the core. In Idle mode all three sources can. An I/O wake leaves a sticky flag behind. The status register also shows the timer request level, so software can tell which source woke it: timer flag set means the timer, I/O flag set means a pin, and neither set means audio.

The clock enable output changes only while the selected processor clock is low, so an external gate cell cannot produce a runt pulse.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: After reset the power-control register (address 0) reads 0x00, status bit 1 reads 0, `cpu_run` is 1, `cpu_clk_fast` is 0 and `ext_bus_oe` is 1.
- R2: Writing address 0 with bit 7 set enters power-down. Bit 7 then reads 1, `ext_bus_oe` is 0 for as long as bit 7 is set, and `cpu_run` falls.
- R3: `cpu_run` changes value only on a clock edge at which `clk_lvl` was 0; while `clk_lvl` is 1 it holds its value.
- R4: In either mode, a wake pin k whose enable bit k (address 1) is 1 and whose level equals bit k of the polarity register (address 2) ends power-down. Bit 7 of address 0 clears and `cpu_run` returns to 1.
- R5: In Sleep mode (address 0 bit 0 = 0), the audio pulse and timer requests leave power-down in place.
- R6: In Idle mode (address 0 bit 0 = 1), a pulse on `audio_det` lasting at least two clocks ends power-down.
- R7: In Idle mode with address 0 bit 6 = 1, a 0-to-1 transition of `tmr_irq` ends power-down. With bit 6 = 0 it has no effect. A request that was already high before entry does not wake.
- R8: `cpu_clk_fast` takes the value of address 0 bit 2 at the moment of a wakeup and otherwise keeps its value, including when bit 2 is written.
- R9: Status bit 1 (address 3) is set by an I/O wake and stays set. Writing address 3 with bit 1 = 0 clears it, and writing bit 1 = 1 does not set it.
- R10: Status bit 0 (address 3) shows the synchronized `tmr_irq` level. After a timer wake it reads 1 with bit 1 = 0. After an audio wake both bits read 0.
- R11: Asynchronous wake inputs pass a two-flop synchronizer. A pin match applied between edges clears the power-down bit on the third rising edge after it appears, not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on slow clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| wake_pins | input | NPIN | Asynchronous I/O pin levels |
| tmr_irq | input | 1 | Timer-2 overflow request flag level |
| audio_det | input | 1 | Audio detector wake pulse |
| clk_lvl | input | 1 | Current level of the selected processor clock |
| cpu_run | output | 1 | Processor clock enable |
| cpu_clk_fast | output | 1 | Processor clock select, 1 = fast |
| ext_bus_oe | output | 1 | External bus drive enable, 0 = release pads |

## Verification
The bench measures the exact synchronizer latency of a pin wake. A design with one stage too few or too many would clear the power-down bit one edge early or one edge late. It checks that Sleep mode rejects the audio and timer sources, which a design that ignores the mode bit would accept. It also checks that a timer request already high at entry, or arriving with its enable off, leaves the core asleep; a level-sensitive detector would wake at once. Finally it holds `clk_lvl` high across entry and exit to catch an enable that switches mid-pulse, and it confirms that writing the clock-select bit has no effect until a wake and that the I/O flag can only be cleared by software.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
    localparam int REG_AW = 2;
    localparam int REG_DW = 8;

    typedef enum logic [REG_AW-1:0] {
        ADR_PCTL  = 2'd0,
        ADR_WKEN  = 2'd1,
        ADR_WKPOL = 2'd2,
        ADR_STAT  = 2'd3
    } reg_addr_e;

    // Bit positions inside the power-control register
    localparam int PC_PDN  = 7;
    localparam int PC_T2EN = 6;
    localparam int PC_FSEL = 2;
    localparam int PC_IDLE = 0;
    // Bit positions inside the status register
    localparam int ST_IOWK = 1;
    localparam int ST_TFLG = 0;
endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = d;
        for (int i = 1; i < STAGES; i++) st_d[i] = st_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q[STAGES-1];
endmodule

// File: rtl/pwr_wake_detect.sv
module pwr_wake_detect #(
    parameter int NPIN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_s,
    input  logic            tirq_s,
    input  logic            aud_s,
    input  logic [NPIN-1:0] wken,
    input  logic [NPIN-1:0] wkpol,
    input  logic            idle,
    input  logic            t2en,
    output logic            io_hit,
    output logic            wake_req
);
    logic tprev_d, tprev_q;
    logic t_rise;

    always_comb begin
        tprev_d  = tirq_s;
        t_rise   = tirq_s & ~tprev_q;
        io_hit   = |(wken & ~(pin_s ^ wkpol));
        wake_req = io_hit | (idle & (aud_s | (t2en & t_rise)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tprev_q <= 1'b0;
        else        tprev_q <= tprev_d;
    end

    // R5: outside Idle mode only a pin match may request a wake
    a_r5_sleep_io_only: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && !io_hit) |-> idle);
    // R7: a timer-only wake needs the request low on the previous edge
    a_r7_timer_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && !io_hit && !aud_s) |-> !$past(tirq_s));
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl
    import pwr_pkg::*;
#(
    parameter int NPIN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic [NPIN-1:0]   wake_pins,
    input  logic              tmr_irq,
    input  logic              audio_det,
    input  logic              clk_lvl,
    output logic              cpu_run,
    output logic              cpu_clk_fast,
    output logic              ext_bus_oe
);
    localparam int SYNC_W = NPIN + 2;

    typedef struct packed {
        logic            pdn;
        logic            t2en;
        logic            fsel;
        logic            idle;
        logic [NPIN-1:0] wken;
        logic [NPIN-1:0] wkpol;
        logic            io_flag;
        logic            run;
        logic            fast;
    } state_t;

    state_t st_d, st_q;

    logic [SYNC_W-1:0] raw_in, syn_out;
    logic [NPIN-1:0]   pin_s;
    logic              tirq_s, aud_s;
    logic              io_hit, wake_req, wake_fire;
    logic              wr_pctl, wr_wken, wr_wkpol, wr_stat;

    assign raw_in = {audio_det, tmr_irq, wake_pins};

    pwr_sync #(.W(SYNC_W), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn_out)
    );

    assign pin_s  = syn_out[NPIN-1:0];
    assign tirq_s = syn_out[NPIN];
    assign aud_s  = syn_out[NPIN+1];

    pwr_wake_detect #(.NPIN(NPIN)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_s    (pin_s),
        .tirq_s   (tirq_s),
        .aud_s    (aud_s),
        .wken     (st_q.wken),
        .wkpol    (st_q.wkpol),
        .idle     (st_q.idle),
        .t2en     (st_q.t2en),
        .io_hit   (io_hit),
        .wake_req (wake_req)
    );

    always_comb begin
        wr_pctl   = reg_we && (reg_addr == ADR_PCTL);
        wr_wken   = reg_we && (reg_addr == ADR_WKEN);
        wr_wkpol  = reg_we && (reg_addr == ADR_WKPOL);
        wr_stat   = reg_we && (reg_addr == ADR_STAT);
        wake_fire = st_q.pdn && wake_req;

        st_d = st_q;
        if (wr_pctl) begin
            st_d.pdn  = reg_wdata[PC_PDN];
            st_d.t2en = reg_wdata[PC_T2EN];
            st_d.fsel = reg_wdata[PC_FSEL];
            st_d.idle = reg_wdata[PC_IDLE];
        end else if (wake_fire) begin
            st_d.pdn  = 1'b0;
            st_d.fast = st_q.fsel;
        end
        if (wr_wken)  st_d.wken  = reg_wdata[NPIN-1:0];
        if (wr_wkpol) st_d.wkpol = reg_wdata[NPIN-1:0];
        if (wr_stat)  st_d.io_flag = st_q.io_flag & reg_wdata[ST_IOWK];
        if (wake_fire && io_hit) st_d.io_flag = 1'b1;
        // clock enable moves only while the selected clock is low
        if (!clk_lvl) st_d.run = !st_q.pdn;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.wkpol <= '1;
            st_q.run   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADR_PCTL: begin
                reg_rdata[PC_PDN]  = st_q.pdn;
                reg_rdata[PC_T2EN] = st_q.t2en;
                reg_rdata[PC_FSEL] = st_q.fsel;
                reg_rdata[PC_IDLE] = st_q.idle;
            end
            ADR_WKEN:  reg_rdata[NPIN-1:0] = st_q.wken;
            ADR_WKPOL: reg_rdata[NPIN-1:0] = st_q.wkpol;
            default: begin
                reg_rdata[ST_IOWK] = st_q.io_flag;
                reg_rdata[ST_TFLG] = tirq_s;
            end
        endcase
    end

    assign cpu_run      = st_q.run;
    assign cpu_clk_fast = st_q.fast;
    assign ext_bus_oe   = !st_q.pdn;

    // R3: the enable toggles only after an edge that saw the clock low
    a_r3_gate_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cpu_run) |-> $past(!clk_lvl));
    // R8: the clock select moves only when power-down ends
    a_r8_sel_at_wake: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cpu_clk_fast) |-> $fell(st_q.pdn));
    // R9: the I/O flag survives every cycle without a status write
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.io_flag && !wr_stat) |=> st_q.io_flag);
    // R5: Sleep mode without a pin match stays powered down
    a_r5_sleep_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pdn && !st_q.idle && !io_hit && !wr_pctl) |=> st_q.pdn);
endmodule

// File: tb/pwr_wake_ctrl_bench.sv
module pwr_wake_ctrl_bench;
    localparam int  NPIN = 8;
    localparam time CYC  = 4ns;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      reg_addr = '0;
    logic            reg_we = 1'b0;
    logic [7:0]      reg_wdata = '0;
    logic [7:0]      reg_rdata;
    logic [NPIN-1:0] wake_pins = '0;
    logic            tmr_irq = 1'b0;
    logic            audio_det = 1'b0;
    logic            clk_lvl = 1'b0;
    logic            cpu_run, cpu_clk_fast, ext_bus_oe;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CYC/2) clk = ~clk;

    pwr_wake_ctrl #(.NPIN(NPIN)) u_pwr_wake_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_addr     (reg_addr),
        .reg_we       (reg_we),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .wake_pins    (wake_pins),
        .tmr_irq      (tmr_irq),
        .audio_det    (audio_det),
        .clk_lvl      (clk_lvl),
        .cpu_run      (cpu_run),
        .cpu_clk_fast (cpu_clk_fast),
        .ext_bus_oe   (ext_bus_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        reg_addr = a;
        #1ns;
        v = reg_rdata;
    endtask

    task automatic pin_wake();
        wake_pins[3] = 1'b1;
        cyc(5);
        wake_pins[3] = 1'b0;
        cyc(4);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(2'd0, v); chk("R1 pctl", v, 8'h00);
        rd(2'd3, v); chk("R1 io flag", {7'b0, v[1]}, 8'h00);
        chk("R1 run", {7'b0, cpu_run}, 8'h01);
        chk("R1 fast", {7'b0, cpu_clk_fast}, 8'h00);
        chk("R1 bus oe", {7'b0, ext_bus_oe}, 8'h01);
    endtask

    task automatic t_io_sync();
        logic [7:0] v;
        wr(2'd0, 8'h84);
        rd(2'd0, v); chk("R2 pdn set", {7'b0, v[7]}, 8'h01);
        chk("R2 bus released", {7'b0, ext_bus_oe}, 8'h00);
        cyc(1);
        chk("R2 run off", {7'b0, cpu_run}, 8'h00);
        wake_pins[3] = 1'b1;
        cyc(2);
        rd(2'd0, v); chk("R11 no early wake", {7'b0, v[7]}, 8'h01);
        cyc(1);
        rd(2'd0, v); chk("R11 wake on third edge", {7'b0, v[7]}, 8'h00);
        chk("R8 fast after wake", {7'b0, cpu_clk_fast}, 8'h01);
        cyc(1);
        chk("R4 run back", {7'b0, cpu_run}, 8'h01);
        chk("R4 bus driven", {7'b0, ext_bus_oe}, 8'h01);
        rd(2'd3, v); chk("R9 io flag set", {7'b0, v[1]}, 8'h01);
        wake_pins[3] = 1'b0;
        cyc(4);
    endtask

    task automatic t_stat_clear();
        logic [7:0] v;
        wr(2'd3, 8'h02);
        rd(2'd3, v); chk("R9 write 1 keeps", {7'b0, v[1]}, 8'h01);
        wr(2'd3, 8'h00);
        rd(2'd3, v); chk("R9 write 0 clears", {7'b0, v[1]}, 8'h00);
        wr(2'd3, 8'h02);
        rd(2'd3, v); chk("R9 write 1 no set", {7'b0, v[1]}, 8'h00);
    endtask

    task automatic t_sleep_ignore();
        logic [7:0] v;
        wr(2'd0, 8'hC0);
        audio_det = 1'b1; tmr_irq = 1'b1;
        cyc(4);
        audio_det = 1'b0;
        cyc(6);
        rd(2'd0, v); chk("R5 sleep holds", {7'b0, v[7]}, 8'h01);
        chk("R5 run stays off", {7'b0, cpu_run}, 8'h00);
        chk("R8 select held asleep", {7'b0, cpu_clk_fast}, 8'h01);
        pin_wake();
        rd(2'd0, v); chk("R4 sleep pin wake", {7'b0, v[7]}, 8'h00);
        chk("R8 slow after wake", {7'b0, cpu_clk_fast}, 8'h00);
        tmr_irq = 1'b0;
        wr(2'd3, 8'h00);
        cyc(4);
    endtask

    task automatic t_idle_audio();
        logic [7:0] v;
        wr(2'd0, 8'h81);
        cyc(4);
        rd(2'd0, v); chk("R6 asleep before pulse", {7'b0, v[7]}, 8'h01);
        audio_det = 1'b1;
        cyc(3);
        audio_det = 1'b0;
        cyc(3);
        rd(2'd0, v); chk("R6 audio wake", {7'b0, v[7]}, 8'h00);
        rd(2'd3, v); chk("R10 audio source", v & 8'h03, 8'h00);
    endtask

    task automatic t_idle_timer();
        logic [7:0] v;
        wr(2'd0, 8'hC1);
        cyc(4);
        rd(2'd0, v); chk("R7 asleep before rise", {7'b0, v[7]}, 8'h01);
        tmr_irq = 1'b1;
        cyc(5);
        rd(2'd0, v); chk("R7 timer wake", {7'b0, v[7]}, 8'h00);
        rd(2'd3, v); chk("R10 timer source", v & 8'h03, 8'h01);
        tmr_irq = 1'b0;
        cyc(3);
    endtask

    task automatic t_timer_blocked();
        logic [7:0] v;
        tmr_irq = 1'b1;
        cyc(4);
        wr(2'd0, 8'hC1);
        cyc(8);
        rd(2'd0, v); chk("R7 preset flag no wake", {7'b0, v[7]}, 8'h01);
        tmr_irq = 1'b0;
        cyc(3);
        wr(2'd0, 8'h81);
        tmr_irq = 1'b1;
        cyc(6);
        rd(2'd0, v); chk("R7 disabled no wake", {7'b0, v[7]}, 8'h01);
        pin_wake();
        tmr_irq = 1'b0;
        wr(2'd3, 8'h00);
        cyc(3);
    endtask

    task automatic t_sel_write();
        logic [7:0] v;
        wr(2'd0, 8'h04);
        cyc(2);
        rd(2'd0, v); chk("R8 select bit stored", {7'b0, v[2]}, 8'h01);
        chk("R8 write no switch", {7'b0, cpu_clk_fast}, 8'h00);
    endtask

    task automatic t_gate();
        clk_lvl = 1'b1;
        wr(2'd0, 8'h84);
        cyc(3);
        chk("R3 run held high", {7'b0, cpu_run}, 8'h01);
        chk("R2 bus released", {7'b0, ext_bus_oe}, 8'h00);
        clk_lvl = 1'b0;
        cyc(1);
        chk("R3 run falls when low", {7'b0, cpu_run}, 8'h00);
        clk_lvl = 1'b1;
        pin_wake();
        chk("R3 run held low", {7'b0, cpu_run}, 8'h00);
        clk_lvl = 1'b0;
        cyc(1);
        chk("R3 run rises when low", {7'b0, cpu_run}, 8'h01);
        chk("R8 fast after wake", {7'b0, cpu_clk_fast}, 8'h01);
    endtask

    initial begin
        #(CYC * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        wr(2'd1, 8'h08);
        wr(2'd2, 8'hFF);
        t_io_sync();
        t_stat_clear();
        t_sleep_ignore();
        t_idle_audio();
        t_idle_timer();
        t_timer_blocked();
        t_sel_write();
        t_gate();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule